// File: doc/BRIEF.md
# Serial Character Framer with Line Control

This block pairs an asynchronous serial transmitter with a receiver. Both take their character format from a small line-control register. The register sets the word length (7 or 8 bits), whether a parity bit is present, whether parity is even or odd, whether the parity bit is forced to a fixed level, and whether one or two stop bits are sent. It also holds a break bit that pulls the serial output low.

The transmitter accepts a byte through a valid/ready handshake. It then shifts out a low start bit, the data bits least-significant first, the optional parity bit and the stop bits, and the line rests high between characters. The receiver watches the serial input at sixteen samples per bit and re-checks the start bit at mid-bit. It returns each character with parity-error, framing-error and break flags. Bit timing comes from an external pulse, `os_tick`, that fires once per sixteenth of a bit.

Top module: `uart_framer`

## Requirements
- R1: After reset the line-control value reads 6'b000001, so the word length is 8 bits and every other field is 0. `txd` is 1 and `tx_ready` is 1.
- R2: A character on `txd` is a 0 start bit, then the data bits LSB first, then the stop bits at 1. Each bit lasts 16 `os_tick` pulses.
- R3: Line-control bit 0 selects 8 data bits when 1 and 7 data bits when 0. In 7-bit mode, transmit bit 7 is not sent and received bit 7 reads 0.
- R4: Line-control bit 2 enables parity. When it is 1, one parity bit follows the data on transmit and is checked on receive. When it is 0, no parity bit is sent or expected.
- R5: Line-control bit 3 selects even parity when 1 and odd parity when 0. The parity counts the data bits together with the parity bit.
- R6: Line-control bit 4 sets stick parity. The parity bit is then the inverse of bit 3 on both transmit and receive.
- R7: Line-control bit 1 selects two stop bits when 1 and one when 0. `tx_ready` returns 1 only after the whole frame, including its stop bits, has been sent.
- R8: The receiver sets `rx_frm_err` when the first stop bit samples 0. It never looks at a second stop bit.
- R9: While line-control bit 5 is 1, `txd` is 0, even in the middle of a character. The character's timing continues, so `tx_ready` returns at the usual time.
- R10: `rx_brk` is set for a received character whose data, parity and first stop bit are all 0.
- R11: If the line is no longer low when the start bit is re-sampled at mid-bit, the falling edge is ignored and no character is reported.
- R12: `rx_par_err` is set when parity is enabled and the received parity bit differs from the expected one.
- R13: A byte is accepted only in a cycle where `tx_valid` and `tx_ready` are both 1. A `tx_valid` raised while a frame is being sent is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Pulse at sixteen times the bit rate |
| lcr_wr | input | 1 | Write strobe for the line-control register |
| lcr_wdata | input | 6 | {break, stick, even, parity enable, two stops, 8-bit word} |
| lcr_q | output | 6 | Current line-control value |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmitter idle and able to accept |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_valid | output | 1 | One-cycle pulse when a character has been received |
| rx_data | output | 8 | Received byte |
| rx_par_err | output | 1 | Parity mismatch on this character |
| rx_frm_err | output | 1 | First stop bit was 0 |
| rx_brk | output | 1 | Data, parity and stop bits were all 0 |

## Verification
Break forcing and character shifting can act on `txd` in the same cycle. The bench sets the break bit while a byte is three bits into its frame. It then checks that `txd` stays 0 while the frame counter keeps running, so `tx_ready` comes back on the normal frame boundary. On the receive side, a framing error and a break can be reported for the same character. An all-zero frame driven with parity enabled must raise the framing, break and parity flags together.

// File: rtl/uart_lc_pkg.sv
package uart_lc_pkg;
  localparam int unsigned LCR_W = 6;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned FRM_W = 12;
  localparam logic [LCR_W-1:0] LCR_RST = 6'b000001;

  typedef struct packed {
    logic brk;
    logic stick;
    logic even;
    logic par_en;
    logic stop2;
    logic word8;
  } lcr_t;

  // parity bit for a character, honouring word length and stick mode
  function automatic logic par_bit(logic [BYTE_W-1:0] d, logic word8,
                                   logic even, logic stick);
    logic [BYTE_W-1:0] m;
    m = word8 ? d : {1'b0, d[BYTE_W-2:0]};
    if (stick) return ~even;
    return even ? ^m : ~(^m);
  endfunction

  // total bit count of one transmitted frame
  function automatic logic [3:0] frame_bits(lcr_t c);
    return 4'd1 + (c.word8 ? 4'd8 : 4'd7) + {3'b0, c.par_en} + (c.stop2 ? 4'd2 : 4'd1);
  endfunction
endpackage

// File: rtl/uart_lc_reg.sv
module uart_lc_reg import uart_lc_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [LCR_W-1:0] wdata,
  output lcr_t             q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= lcr_t'(LCR_RST);
    else if (wr) q <= lcr_t'(wdata);
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx import uart_lc_pkg::*; #(
  parameter int unsigned OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  lcr_t              cfg,
  input  logic              valid,
  input  logic [BYTE_W-1:0] data,
  output logic              ready,
  output logic              txd,
  output logic              bit_end
);
  localparam int unsigned CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);

  logic [FRM_W-1:0] sh, frame;
  logic [3:0]       left;
  logic [CNT_W-1:0] cnt;
  logic             busy;
  logic [3:0]       ppos;

  assign bit_end = busy && tick && (cnt == CNT_LAST);

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < BYTE_W; i++)
      if (i < BYTE_W - 1 || cfg.word8) frame[i+1] = data[i];
    ppos = cfg.word8 ? 4'd9 : 4'd8;
    if (cfg.par_en) frame[ppos] = par_bit(data, cfg.word8, cfg.even, cfg.stick);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      left <= '0;
      cnt  <= '0;
    end else if (!busy) begin
      if (valid) begin
        busy <= 1'b1;
        sh   <= frame;
        left <= frame_bits(cfg);
        cnt  <= '0;
      end
    end else if (tick) begin
      cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
      if (bit_end) begin
        sh   <= {1'b1, sh[FRM_W-1:1]};
        left <= left - 4'd1;
        if (left == 4'd1) busy <= 1'b0;
      end
    end
  end

  assign ready = !busy;
  assign txd   = cfg.brk ? 1'b0 : sh[0];
endmodule

// File: rtl/uart_rx.sv
module uart_rx import uart_lc_pkg::*; #(
  parameter int unsigned OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  lcr_t              cfg,
  input  logic              rxd,
  output logic              valid,
  output logic [BYTE_W-1:0] data,
  output logic              par_err,
  output logic              frm_err,
  output logic              brk,
  output logic              snap_word8,
  output logic              snap_par_en,
  output logic              stop_samp
);
  localparam int unsigned CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OSR / 2 - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_t;

  rx_st_t            st;
  logic [1:0]        sy;
  logic              rxs;
  logic [CNT_W-1:0]  cnt;
  logic [3:0]        idx, dbits;
  logic [BYTE_W-1:0] dat;
  logic              pbit, s_even, s_stick;
  logic              samp;

  assign rxs       = sy[1];
  assign dbits     = snap_word8 ? 4'd8 : 4'd7;
  assign samp      = (st == RX_BITS) && tick && (cnt == CNT_LAST);
  assign stop_samp = samp && (idx == dbits + {3'b0, snap_par_en});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE; sy <= 2'b11; cnt <= '0; idx <= '0; dat <= '0; pbit <= 1'b0;
      snap_word8 <= 1'b1; snap_par_en <= 1'b0; s_even <= 1'b0; s_stick <= 1'b0;
      valid <= 1'b0; data <= '0; par_err <= 1'b0; frm_err <= 1'b0; brk <= 1'b0;
    end else begin
      sy    <= {sy[0], rxd};
      valid <= 1'b0;
      case (st)
        RX_IDLE: if (tick && !rxs) begin
          st <= RX_START; cnt <= '0;
          snap_word8 <= cfg.word8; snap_par_en <= cfg.par_en;
          s_even <= cfg.even; s_stick <= cfg.stick;
        end
        RX_START: if (tick) begin
          if (cnt == CNT_MID) begin
            cnt <= '0; idx <= '0; dat <= '0; pbit <= 1'b0;
            st  <= rxs ? RX_IDLE : RX_BITS;
          end else cnt <= cnt + 1'b1;
        end
        RX_BITS: if (tick) begin
          cnt <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
          if (samp) begin
            idx <= idx + 4'd1;
            if (idx < dbits) dat[idx[2:0]] <= rxs;
            else if (!stop_samp) pbit <= rxs;
            else begin
              valid   <= 1'b1;
              data    <= dat;
              frm_err <= !rxs;
              par_err <= snap_par_en && (pbit != par_bit(dat, snap_word8, s_even, s_stick));
              brk     <= (dat == '0) && (!snap_par_en || !pbit) && !rxs;
              st      <= RX_IDLE;
            end
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_framer.sv
module uart_framer import uart_lc_pkg::*; #(
  parameter int unsigned OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              lcr_wr,
  input  logic [LCR_W-1:0]  lcr_wdata,
  output logic [LCR_W-1:0]  lcr_q,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              txd,
  input  logic              rxd,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_par_err,
  output logic              rx_frm_err,
  output logic              rx_brk
);
  lcr_t cfg;
  logic tx_bit_end_w, rx_word8_w, rx_par_en_w, rx_stop_samp_w;

  uart_lc_reg u_lcr (.clk(clk), .rst_n(rst_n), .wr(lcr_wr), .wdata(lcr_wdata), .q(cfg));
  assign lcr_q = cfg;

  uart_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .cfg(cfg), .valid(tx_valid),
    .data(tx_data), .ready(tx_ready), .txd(txd), .bit_end(tx_bit_end_w));

  uart_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .cfg(cfg), .rxd(rxd),
    .valid(rx_valid), .data(rx_data), .par_err(rx_par_err), .frm_err(rx_frm_err),
    .brk(rx_brk), .snap_word8(rx_word8_w), .snap_par_en(rx_par_en_w),
    .stop_samp(rx_stop_samp_w));
endmodule

// File: rtl/uart_framer_chk.sv
module uart_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] lcr_q,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       rx_par_err,
  input logic       rx_frm_err,
  input logic       rx_brk,
  input logic       rx_word8,
  input logic       rx_par_en,
  input logic       rx_stop_samp
);
  // R9
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n) lcr_q[5] |-> !txd);
  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n) (tx_ready && !lcr_q[5]) |-> txd);
  // R13
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (tx_valid && tx_ready) |=> !tx_ready);
  // R10
  brk_frame_chk: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && rx_brk) |-> (rx_frm_err && rx_data == 8'h00));
  // R3
  narrow_msb_chk: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && !rx_word8) |-> !rx_data[7]);
  // R12
  par_off_chk: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && !rx_par_en) |-> !rx_par_err);
  // R8
  stop_report_chk: assert property (@(posedge clk) disable iff (!rst_n) rx_stop_samp |=> rx_valid);
endmodule

bind uart_framer uart_framer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .lcr_q(lcr_q), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .txd(txd), .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
  .rx_frm_err(rx_frm_err), .rx_brk(rx_brk), .rx_word8(rx_word8_w),
  .rx_par_en(rx_par_en_w), .rx_stop_samp(rx_stop_samp_w));

// File: tb/uart_framer_tb_top.sv
module uart_framer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0;
  logic lcr_wr = 1'b0, tx_valid = 1'b0, use_loop = 1'b1, rx_drv = 1'b1;
  logic [5:0] lcr_wdata = '0, lcr_q;
  logic [7:0] tx_data = '0, rx_data;
  logic tx_ready, txd, rxd, rx_valid, rx_par_err, rx_frm_err, rx_brk;
  int n_chk = 0, n_bad = 0, cap_total = 0;
  logic [7:0] cap_d = '0;
  logic cap_pe = 1'b0, cap_fe = 1'b0, cap_bk = 1'b0;

  always #10 clk = ~clk;
  assign rxd = use_loop ? txd : rx_drv;

  uart_framer dut_i (.*);

  initial forever begin @(negedge clk); os_tick = ~os_tick; end

  always @(negedge clk) if (rst_n && rx_valid) begin
    cap_total <= cap_total + 1; cap_d <= rx_data;
    cap_pe <= rx_par_err; cap_fe <= rx_frm_err; cap_bk <= rx_brk;
  end

  // {lcr, data, expected rx byte, parity bit (2 = none)}
  localparam int NV = 12;
  localparam logic [23:0] VEC [NV] = '{
    {6'h01, 8'hA5, 8'hA5, 2'd2}, {6'h00, 8'hA5, 8'h25, 2'd2},
    {6'h05, 8'h0F, 8'h0F, 2'd1}, {6'h0D, 8'h0F, 8'h0F, 2'd0},
    {6'h0D, 8'h07, 8'h07, 2'd1}, {6'h05, 8'h07, 8'h07, 2'd0},
    {6'h1D, 8'h01, 8'h01, 2'd0}, {6'h15, 8'h01, 8'h01, 2'd1},
    {6'h03, 8'h3C, 8'h3C, 2'd2}, {6'h04, 8'h81, 8'h01, 2'd0},
    {6'h0E, 8'hFE, 8'h7E, 2'd0}, {6'h01, 8'h00, 8'h00, 2'd2}};

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_lcr(input logic [5:0] v);
    @(negedge clk); lcr_wr = 1'b1; lcr_wdata = v;
    @(negedge clk); lcr_wr = 1'b0;
  endtask

  task automatic send_tx(input logic [7:0] d);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = d;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic rx_bits(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_drv = v[i];
      wait_n(31);
    end
    @(negedge clk); rx_drv = 1'b1;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] fr;
    int nb, base;
    wait_n(3);
    // R1 reset state
    chk("R1", "lcr reset", lcr_q, 6'h01);
    chk("R1", "txd idle", txd, 1);
    chk("R1", "ready", tx_ready, 1);
    rst_n = 1'b1;
    wait_n(4);
    chk("R1", "lcr after release", lcr_q, 6'h01);

    for (int v = 0; v < NV; v++) begin
      logic [5:0] l; logic [7:0] d, e; logic [1:0] p; string rq;
      {l, d, e, p} = VEC[v];
      write_lcr(l);
      // expected frame: start, data, optional parity, stops
      fr = '1; nb = 0;
      fr[nb++] = 1'b0;
      for (int k = 0; k < (l[0] ? 8 : 7); k++) fr[nb++] = d[k];
      if (p != 2'd2) fr[nb++] = p[0];
      nb += l[1] ? 2 : 1;
      rq = l[4] ? "R6" : (l[2] ? "R5" : (l[0] ? "R2" : "R3"));
      base = cap_total;
      send_tx(d);
      wait_n(15);
      begin
        logic [15:0] got; got = '1;
        for (int k = 0; k < nb; k++) begin
          got[k] = txd;
          if (k < nb - 1) wait_n(32);
        end
        chk(rq, $sformatf("tx frame vec %0d", v), got, fr);
      end
      wait_n(8);
      chk("R7", $sformatf("busy at frame end vec %0d", v), tx_ready, 0);
      wait_n(12);
      chk("R7", $sformatf("ready after frame vec %0d", v), tx_ready, 1);
      chk("R4", $sformatf("rx char vec %0d", v), {cap_total - base, cap_d, cap_pe, cap_fe, cap_bk},
          {32'd1 , e, 3'b000});
    end

    // R13: valid during busy is ignored
    write_lcr(6'h01);
    base = cap_total;
    send_tx(8'h11);
    wait_n(50);
    @(negedge clk); tx_valid = 1'b1; tx_data = 8'h22;
    wait_n(10);
    @(negedge clk); tx_valid = 1'b0;
    wait_n(280);
    chk("R13", "ready after single frame", tx_ready, 1);
    wait_n(60);
    chk("R13", "line stays idle", txd, 1);
    chk("R13", "one char received", {cap_total - base, cap_d}, {32'd1, 8'h11});

    // R9: break mid character
    use_loop = 1'b0;
    send_tx(8'hFF);
    wait_n(100);
    write_lcr(6'h21);
    wait_n(2);
    chk("R9", "txd forced low", txd, 0);
    wait_n(100);
    chk("R9", "txd still low", txd, 0);
    wait_n(95);
    chk("R9", "frame still busy", tx_ready, 0);
    wait_n(30);
    chk("R9", "ready on normal boundary", {tx_ready, txd}, 2'b10);
    write_lcr(6'h01);
    wait_n(2);
    chk("R9", "line high after release", txd, 1);

    // R8: second stop bit low is not checked
    write_lcr(6'h03);
    base = cap_total;
    rx_bits({5'b0, 1'b0, 1'b1, 8'h55, 1'b0}, 11);
    chk("R8", "second stop ignored", {cap_total - base, cap_d, cap_fe, cap_bk}, {32'd1, 8'h55, 2'b00});
    wait_n(500);
    // R8: first stop low
    write_lcr(6'h01);
    base = cap_total;
    rx_bits({6'b0, 1'b0, 8'h3C, 1'b0}, 10);
    chk("R8", "first stop low", {cap_total - base, cap_d, cap_fe, cap_bk}, {32'd1, 8'h3C, 2'b10});
    wait_n(200);
    // R10 with R12: all-zero frame, odd parity
    write_lcr(6'h05);
    base = cap_total;
    rx_bits(16'h0000, 11);
    chk("R10", "break char flags", {cap_total - base, cap_d, cap_pe, cap_fe, cap_bk},
        {32'd1, 8'h00, 3'b111});
    wait_n(200);
    // R12: wrong even parity
    write_lcr(6'h0D);
    base = cap_total;
    rx_bits({5'b0, 1'b1, 1'b0, 8'h01, 1'b0}, 11);
    chk("R12", "parity error", {cap_total - base, cap_d, cap_pe, cap_fe, cap_bk},
        {32'd1, 8'h01, 3'b100});
    wait_n(200);
    // R11: short low pulse rejected
    base = cap_total;
    @(negedge clk); rx_drv = 1'b0;
    wait_n(6);
    rx_drv = 1'b1;
    wait_n(800);
    chk("R11", "glitch no char", cap_total - base, 0);

    summary();
  end
endmodule